// File: doc/BRIEF.md
# Dead-Zone Coefficient Quantizer and Reconstructor

This block quantizes and reconstructs transform coefficients for a block-based video encoder. It is shaped like a processor's extension unit: two 32-bit operands go in and one 32-bit result comes out. Operand A carries a coefficient or a quantized level. Operand B carries the quantizer parameter in its low five bits. A two-bit function select picks one of four operations. Two are forward quantizers, one without a dead zone for intra blocks and one with a dead zone for inter blocks. The third quantizes the intra DC term with a fixed step of 8. The fourth reconstructs a coefficient from a level.

All the arithmetic is combinational. The result is captured in one output register, so each operation's answer is on the result port after the next rising clock edge. A fresh operation can be issued every cycle. An encoder loop calls the forward functions on each transform output and calls the reconstruction function on each level to rebuild its reference picture.

Top module: `qdz_unit`

## Requirements
- R1: While `rst` is high, `result_o` reads 0 after each rising edge, whatever the operands and function select are.
- R2: Function code 2'b00 (intra) returns floor(|A| / (2*QP)), with the sign of A applied. A result of zero has no sign.
- R3: Function code 2'b01 (inter) first forms N = |A| - floor(QP/2). It returns 0 when N is negative and floor(N / (2*QP)) otherwise, with the sign of A applied.
- R4: The forward magnitude in codes 2'b00 and 2'b01 is clipped to 127, so the result lies within -127..127. This holds for A = -2^31 as well.
- R5: Function code 2'b10 (DC) returns floor((A + 4) / 8), that is, A/8 rounded half up, clipped to 1..254. Any A <= 0 gives 1, and operand B is ignored.
- R6: Function code 2'b11 (reconstruct) with A = 0 returns 0.
- R7: In reconstruction with QP odd and a nonzero level L = A, the magnitude is QP*(2|L|+1) and the sign is that of L.
- R8: In reconstruction with QP even and a nonzero level, the magnitude is QP*(2|L|+1) - 1 and the sign is that of L.
- R9: Reconstructed values are clipped to -2048..2047, including for very large levels.
- R10: QP is taken from B[4:0] and bits B[31:5] are ignored. A QP field of 0 is handled as QP = 1.
- R11: The result of the operands present before a rising edge appears on `result_o` just after that edge. It stays unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 2 | Operation: 00 intra, 01 inter, 10 intra DC, 11 reconstruct |
| opa_i | input | 32 | Coefficient (forward, DC) or level (reconstruct), two's complement |
| opb_i | input | 32 | Quantizer parameter in bits 4:0 |
| result_o | output | 32 | Registered result, two's complement |

## Verification
Every result is due exactly one rising edge after its operands are applied, because a single output register follows the arithmetic. The bench changes operands on the falling edge and samples `result_o` on the following falling edge, halfway between captures. The latency test also samples a few nanoseconds after the change and before the next rising edge, to confirm the old value still holds. It then samples across several idle edges to confirm the new value stays put. Reset is checked the same way: one edge after it is asserted, and again while it is held.

// File: rtl/qdz_pkg.sv
package qdz_pkg;

  typedef enum logic [1:0] {
    QF_INTRA = 2'b00,
    QF_INTER = 2'b01,
    QF_DC    = 2'b10,
    QF_RECON = 2'b11
  } qfunc_e;

endpackage

// File: rtl/qdz_fwd.sv
module qdz_fwd #(
  parameter int DW      = 32,
  parameter int QW      = 5,
  parameter int LVL_MAX = 127
) (
  input  logic [DW-1:0] coef_i,
  input  logic [QW-1:0] qp_i,
  input  logic          inter_i,
  output logic [DW-1:0] level_o
);

  localparam int MW = DW + 1;

  logic signed [MW-1:0] cx;
  logic [MW-1:0] mag;
  logic [MW-1:0] half;
  logic [MW-1:0] num;
  logic [MW-1:0] divisor;
  logic [MW-1:0] quot;
  logic [MW-1:0] lim;
  logic          neg;

  always_comb begin
    cx      = {coef_i[DW-1], coef_i};
    mag     = (cx < 0) ? MW'(-cx) : MW'(cx);
    half    = MW'(qp_i >> 1);
    if (!inter_i)
      num = mag;
    else if (mag < half)
      num = '0;
    else
      num = mag - half;
    divisor = MW'({qp_i, 1'b0});
    quot    = num / divisor;
    lim     = (quot > MW'(LVL_MAX)) ? MW'(LVL_MAX) : quot;
    neg     = coef_i[DW-1] && (lim != '0);
    level_o = neg ? DW'(-lim) : DW'(lim);
  end

endmodule

// File: rtl/qdz_dc.sv
module qdz_dc #(
  parameter int DW     = 32,
  parameter int STEP   = 8,
  parameter int DC_MIN = 1,
  parameter int DC_MAX = 254
) (
  input  logic [DW-1:0] coef_i,
  output logic [DW-1:0] dc_o
);

  localparam int SH   = $clog2(STEP);
  localparam int HALF = STEP / 2;
  localparam int MW   = DW + 1;

  logic [MW-1:0] sum;
  logic [MW-1:0] q;

  always_comb begin
    sum = {1'b0, coef_i} + MW'(HALF);
    q   = sum >> SH;
    if (coef_i[DW-1] || coef_i == '0 || q < MW'(DC_MIN))
      dc_o = DW'(DC_MIN);
    else if (q > MW'(DC_MAX))
      dc_o = DW'(DC_MAX);
    else
      dc_o = DW'(q);
  end

endmodule

// File: rtl/qdz_inv.sv
module qdz_inv #(
  parameter int DW        = 32,
  parameter int QW        = 5,
  parameter int RECON_MAX = 2047
) (
  input  logic [DW-1:0] level_i,
  input  logic [QW-1:0] qp_i,
  output logic [DW-1:0] recon_o
);

  localparam int MW  = DW + 1;
  localparam int CAP = RECON_MAX + 1;
  localparam int CW  = $clog2(CAP) + 2;
  localparam int PW  = QW + CW + 1;

  logic signed [MW-1:0] lx;
  logic [MW-1:0] mag;
  logic [CW-1:0] mcap;
  logic [CW:0]   odd;
  logic [PW-1:0] prod;
  logic [PW-1:0] adj;
  logic          neg;

  always_comb begin
    lx   = {level_i[DW-1], level_i};
    mag  = (lx < 0) ? MW'(-lx) : MW'(lx);
    mcap = (mag > MW'(CAP)) ? CW'(CAP) : mag[CW-1:0];
    odd  = {mcap, 1'b1};
    prod = PW'(qp_i) * PW'(odd);
    adj  = qp_i[0] ? prod : prod - PW'(1);
    neg  = level_i[DW-1];
    if (level_i == '0)
      recon_o = '0;
    else if (neg)
      recon_o = (adj > PW'(CAP)) ? DW'(-CAP) : DW'(-adj);
    else
      recon_o = (adj > PW'(RECON_MAX)) ? DW'(RECON_MAX) : DW'(adj);
  end

endmodule

// File: rtl/qdz_unit.sv
module qdz_unit
  import qdz_pkg::*;
#(
  parameter int DW        = 32,
  parameter int QW        = 5,
  parameter int LVL_MAX   = 127,
  parameter int DC_STEP   = 8,
  parameter int DC_MIN    = 1,
  parameter int DC_MAX    = 254,
  parameter int RECON_MAX = 2047
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    func_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic [DW-1:0] result_o
);

  localparam int RECON_MIN = -(RECON_MAX + 1);

  qfunc_e        func;
  logic [QW-1:0] qp_raw;
  logic [QW-1:0] qp_eff;
  logic [DW-1:0] fwd_res;
  logic [DW-1:0] dc_res;
  logic [DW-1:0] inv_res;
  logic [DW-1:0] sel_res;

  // QP field 0 would divide by zero; treat it as 1 (R10)
  always_comb begin
    func   = qfunc_e'(func_i);
    qp_raw = opb_i[QW-1:0];
    qp_eff = (qp_raw == '0) ? QW'(1) : qp_raw;
  end

  qdz_fwd #(.DW(DW), .QW(QW), .LVL_MAX(LVL_MAX)) fwd_i (
    .coef_i (opa_i),
    .qp_i   (qp_eff),
    .inter_i(func == QF_INTER),
    .level_o(fwd_res)
  );

  qdz_dc #(.DW(DW), .STEP(DC_STEP), .DC_MIN(DC_MIN), .DC_MAX(DC_MAX)) dc_i (
    .coef_i(opa_i),
    .dc_o  (dc_res)
  );

  qdz_inv #(.DW(DW), .QW(QW), .RECON_MAX(RECON_MAX)) inv_i (
    .level_i(opa_i),
    .qp_i   (qp_eff),
    .recon_o(inv_res)
  );

  always_comb begin
    unique case (func)
      QF_INTRA, QF_INTER: sel_res = fwd_res;
      QF_DC:              sel_res = dc_res;
      default:            sel_res = inv_res;
    endcase
  end

  // single output register: result due one edge after operands (R11)
  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= sel_res;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result_o == '0));

  a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
    (func_i == QF_INTRA || func_i == QF_INTER) |=>
      ($signed(result_o) <= LVL_MAX && $signed(result_o) >= -LVL_MAX));

  a_r2_sign_follows: assert property (@(posedge clk) disable iff (rst)
    ((func_i == QF_INTRA || func_i == QF_INTER) && !opa_i[DW-1]) |=>
      !result_o[DW-1]);

  a_r5_dc_range: assert property (@(posedge clk) disable iff (rst)
    (func_i == QF_DC) |=>
      ($signed(result_o) >= DC_MIN && $signed(result_o) <= DC_MAX));

  a_r6_zero_level: assert property (@(posedge clk) disable iff (rst)
    (func_i == QF_RECON && opa_i == '0) |=> (result_o == '0));

  a_r9_recon_range: assert property (@(posedge clk) disable iff (rst)
    (func_i == QF_RECON) |=>
      ($signed(result_o) >= RECON_MIN && $signed(result_o) <= RECON_MAX));

endmodule

// File: tb/qdz_unit_tb_top.sv
module qdz_unit_tb_top;

  typedef struct packed {
    logic [1:0]  f;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    // R2 intra
    '{2'd0, 32'd100,        32'd5,  32'd10,         4'd2},
    '{2'd0, 32'hFFFFFF9C,   32'd5,  32'hFFFFFFF6,   4'd2},
    '{2'd0, 32'd19,         32'd5,  32'd1,          4'd2},
    '{2'd0, 32'd9,          32'd5,  32'd0,          4'd2},
    // R4 clip
    '{2'd0, 32'd10000,      32'd1,  32'd127,        4'd4},
    '{2'd0, 32'hFFFFD8F0,   32'd1,  32'hFFFFFF81,   4'd4},
    '{2'd0, 32'h80000000,   32'd31, 32'hFFFFFF81,   4'd4},
    '{2'd1, 32'd10000,      32'd2,  32'd127,        4'd4},
    // R3 inter
    '{2'd1, 32'd100,        32'd5,  32'd9,          4'd3},
    '{2'd1, 32'hFFFFFF9C,   32'd5,  32'hFFFFFFF7,   4'd3},
    '{2'd1, 32'd2,          32'd5,  32'd0,          4'd3},
    '{2'd1, 32'd1,          32'd5,  32'd0,          4'd3},
    '{2'd1, 32'd12,         32'd5,  32'd1,          4'd3},
    '{2'd1, 32'd11,         32'd4,  32'd1,          4'd3},
    '{2'd1, 32'hFFFFFFF5,   32'd4,  32'hFFFFFFFF,   4'd3},
    '{2'd1, 32'hFFFFFFEF,   32'd8,  32'd0,          4'd3},
    // R5 DC
    '{2'd2, 32'd100,        32'd123, 32'd13,        4'd5},
    '{2'd2, 32'd4,          32'd0,  32'd1,          4'd5},
    '{2'd2, 32'd3,          32'd9,  32'd1,          4'd5},
    '{2'd2, 32'd12,         32'd9,  32'd2,          4'd5},
    '{2'd2, 32'hFFFFFFCE,   32'd9,  32'd1,          4'd5},
    '{2'd2, 32'd0,          32'd9,  32'd1,          4'd5},
    '{2'd2, 32'd2040,       32'd9,  32'd254,        4'd5},
    '{2'd2, 32'd2035,       32'd9,  32'd254,        4'd5},
    // R6 zero level
    '{2'd3, 32'd0,          32'd5,  32'd0,          4'd6},
    // R7 odd QP
    '{2'd3, 32'd3,          32'd5,  32'd35,         4'd7},
    '{2'd3, 32'hFFFFFFFD,   32'd5,  32'hFFFFFFDD,   4'd7},
    // R8 even QP
    '{2'd3, 32'd3,          32'd4,  32'd27,         4'd8},
    '{2'd3, 32'hFFFFFFFF,   32'd2,  32'hFFFFFFFB,   4'd8},
    // R9 clip
    '{2'd3, 32'd100,        32'd31, 32'd2047,       4'd9},
    '{2'd3, 32'hFFFFFF9C,   32'd31, 32'hFFFFF800,   4'd9},
    '{2'd3, 32'd33,         32'd31, 32'd2047,       4'd9},
    '{2'd3, 32'hFFFFFFDF,   32'd31, 32'hFFFFF800,   4'd9},
    '{2'd3, 32'd32,         32'd31, 32'd2015,       4'd9},
    '{2'd3, 32'h80000000,   32'd31, 32'hFFFFF800,   4'd9},
    // R10 QP field
    '{2'd0, 32'd100,        32'hFFFFFFE5, 32'd10,   4'd10},
    '{2'd0, 32'd7,          32'd0,  32'd3,          4'd10},
    '{2'd3, 32'd2,          32'd0,  32'd5,          4'd10},
    '{2'd1, 32'd7,          32'd32, 32'd3,          4'd10},
    '{2'd3, 32'd1,          32'hFFFFFF03, 32'd9,    4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  func_i = 2'd0;
  logic [31:0] opa_i  = 32'd0;
  logic [31:0] opb_i  = 32'd0;
  logic [31:0] result_o;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  qdz_unit dut_i (
    .clk     (clk),
    .rst     (rst),
    .func_i  (func_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .result_o(result_o)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %0d (0x%08h) expected %0d (0x%08h)",
               req, $signed(got), got, $signed(exp), exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    func_i = f;
    opa_i  = a;
    opb_i  = b;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds the result at zero despite live operands
    apply(2'd0, 32'd100, 32'd5);
    @(negedge clk);
    check(1, result_o, 32'd0);
    @(negedge clk);
    check(1, result_o, 32'd0);
    rst = 1'b0;

    // table walk, one result per cycle
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].f, VEC[i].a, VEC[i].b);
      @(negedge clk);
      check(int'(VEC[i].r), result_o, VEC[i].e);
    end

    // R11: latency and hold
    apply(2'd0, 32'd100, 32'd5);
    @(negedge clk);
    check(11, result_o, 32'd10);
    func_i = 2'd3;
    opa_i  = 32'd3;
    #5;
    check(11, result_o, 32'd10);
    @(negedge clk);
    check(11, result_o, 32'd35);
    @(negedge clk);
    check(11, result_o, 32'd35);
    @(negedge clk);
    check(11, result_o, 32'd35);

    // R1: reset mid-run clears and keeps clearing
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1, result_o, 32'd0);
    @(negedge clk);
    check(1, result_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(7, result_o, 32'd35);

    finish_run();
  end

endmodule